// File: doc/BRIEF.md
# Filtered Branch Record Capture Buffer

This block watches a stream of retired branches and keeps a history of the ones that pass a filter. Each branch arrives with a 3-bit class code, a source address, a target address and a strobe. A separate transaction-failed pulse may arrive in any cycle. The records are held in a 64-entry shift store. The newest record sits at index 0, and the oldest one falls off the far end.

A 32-bit control word sets the filter. Software reads and writes it through a single-cycle register port. The word holds:
- one match enable per branch class,
- an invert select that turns the filter from include into exclude,
- a pause flag that freezes capture,
- a 2-bit bank select,
- a sticky failure flag.

Software reads the store one record at a time. The bank select picks a 32-record window and a 5-bit index picks the record inside it.

Class codes are 0 direct, 1 indirect, 2 direct call, 3 indirect call and 4 return. Codes 5 to 7 match no enable.

Top module: `brb_capture`

## Requirements
- R1: After a synchronous active-low reset, the control word reads 0 and every record reads as invalid with all fields zero.
- R2: Control word layout:
  - bank select at bits 29:28,
  - direct-call enable at bit 21, indirect-call enable at bit 20,
  - return enable at bit 19, indirect enable at bit 18, direct enable at bit 17,
  - invert select at bit 16,
  - pause at bit 7, failure flag at bit 6.

  All other bits read 0, and writes to them are ignored. A write takes effect from the next cycle.
- R3: With invert at 0 and pause at 0, a strobed branch is recorded exactly when the enable for its class is 1. Codes 5 to 7 are never recorded in this mode.
- R4: With invert at 1 and pause at 0, a strobed branch is recorded exactly when its class is not enabled. This includes codes 5 to 7.
- R5: While pause reads 1, no record is written and every stored record stays unchanged.
- R6: A new record enters at index 0 and every older record moves up one index. The record at index 63 is discarded.
- R7: Bank code 00 reads records 0 to 31 and code 01 reads records 32 to 63, with the index selecting within the bank. Codes 10 and 11 are stored and read back in the control word, but record reads under them return all zeros.
- R8: The failure flag becomes 1 in the cycle after a failure pulse that does not coincide with a new record. It then stays at 1 until a record is written. A register write loads bit 6 from the written data, unless a failure pulse or a record occurs in the same cycle.
- R9: A new record stores (flag OR same-cycle failure pulse) in its failure bit, and the flag reads 0 in the next cycle.
- R10: Each record read returns a valid bit, the source address, the target address, the 3-bit class code and the failure bit of the selected record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| br_valid | input | 1 | Retired branch strobe |
| br_class | input | 3 | Branch class code |
| br_src | input | AW | Branch source address |
| br_tgt | input | AW | Branch target address |
| br_fail | input | 1 | Transaction-failed pulse |
| rd_idx | input | 5 | Record index within the selected bank |
| rd_valid | output | 1 | Selected record valid |
| rd_src | output | AW | Selected record source address |
| rd_tgt | output | AW | Selected record target address |
| rd_class | output | 3 | Selected record class code |
| rd_fail | output | 1 | Selected record failure bit |

## Verification
Three pairs of events can fall in the same cycle:
- a failure pulse and a branch that gets recorded,
- a register write and a branch,
- a register write and a failure pulse.

The random phase drives failure pulses, branch strobes and control writes independently, so these pairs collide often. Directed steps force a pulse exactly on a recorded branch, and then on a filtered-out branch. The bench judges each case against a cycle model. The pulse must land in the new record and leave the flag clear. When the branch is filtered out instead, the flag must be left set. A branch in a write cycle must be filtered under the old control word.

// File: rtl/brb_pkg.sv
// Package: shared encodings for the branch record capture block.
// Assumes a 32-bit control word; class codes above 4 match no enable.
package brb_pkg;

    typedef enum logic [2:0] {
        CLS_DIR   = 3'd0,
        CLS_IND   = 3'd1,
        CLS_DCALL = 3'd2,
        CLS_ICALL = 3'd3,
        CLS_RET   = 3'd4
    } br_cls_e;

    localparam int CW_W        = 32;
    localparam int POS_BANK_LO = 28;
    localparam int POS_BANK_HI = 29;
    localparam int POS_EN_LO   = 17;   // enables at 17..21: dir, ind, ret, icall, dcall
    localparam int POS_EN_HI   = 21;
    localparam int POS_INV     = 16;
    localparam int POS_PAUSE   = 7;
    localparam int POS_FAIL    = 6;
    localparam int N_EN        = POS_EN_HI - POS_EN_LO + 1;

    // Enable vector index for each class
    localparam int EN_DIR   = 0;
    localparam int EN_IND   = 1;
    localparam int EN_RET   = 2;
    localparam int EN_ICALL = 3;
    localparam int EN_DCALL = 4;

    localparam logic [CW_W-1:0] CTL_MASK = 32'h303F_00C0;

endpackage

// File: rtl/brb_ctrl.sv
// Module: brb_ctrl
// Holds the control word: bank select, class enables, invert, pause and the
// sticky failure flag. Assumes the record push is computed from this cycle's
// registered fields, so a write affects filtering from the next cycle.
module brb_ctrl
    import brb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CW_W-1:0]  wdata,
    input  logic             fail_in,
    input  logic             push,
    output logic [CW_W-1:0]  rdata,
    output logic [1:0]       bank,
    output logic [N_EN-1:0]  en,
    output logic             inv,
    output logic             pause,
    output logic             fail_flag
);

    logic fail_nxt;

    // Next failure flag: a record clears it, a pulse sets it, a write loads it
    always_comb begin
        if (push)
            fail_nxt = 1'b0;
        else
            fail_nxt = (wr ? wdata[POS_FAIL] : fail_flag) | fail_in;
    end

    // Software-owned fields load on a write and clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank  <= '0;
            en    <= '0;
            inv   <= 1'b0;
            pause <= 1'b0;
        end else if (wr) begin
            bank  <= wdata[POS_BANK_HI:POS_BANK_LO];
            en    <= wdata[POS_EN_HI:POS_EN_LO];
            inv   <= wdata[POS_INV];
            pause <= wdata[POS_PAUSE];
        end
    end

    // Sticky failure flag register
    always_ff @(posedge clk) begin
        if (!rst_n) fail_flag <= 1'b0;
        else        fail_flag <= fail_nxt;
    end

    // Assemble the read view; reserved positions stay zero
    always_comb begin
        rdata = '0;
        rdata[POS_BANK_HI:POS_BANK_LO] = bank;
        rdata[POS_EN_HI:POS_EN_LO]     = en;
        rdata[POS_INV]                 = inv;
        rdata[POS_PAUSE]               = pause;
        rdata[POS_FAIL]                = fail_flag;
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdata & ~CTL_MASK) == '0);

    // R9
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !fail_flag);

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_in && !push) |=> fail_flag);

endmodule

// File: rtl/brb_filter.sv
// Module: brb_filter
// Decides whether a strobed branch is kept. Assumes the enable order of
// brb_pkg; unknown class codes never hit an enable.
module brb_filter
    import brb_pkg::*;
(
    input  logic [2:0]       cls,
    input  logic [N_EN-1:0]  en,
    input  logic             inv,
    output logic             keep
);

    logic hit;

    // Look up the enable for this class
    always_comb begin
        case (cls)
            CLS_DIR:   hit = en[EN_DIR];
            CLS_IND:   hit = en[EN_IND];
            CLS_DCALL: hit = en[EN_DCALL];
            CLS_ICALL: hit = en[EN_ICALL];
            CLS_RET:   hit = en[EN_RET];
            default:   hit = 1'b0;
        endcase
    end

    // Include or exclude the match
    always_comb keep = hit ^ inv;

endmodule

// File: rtl/brb_store.sv
// Module: brb_store
// Shift store of NUM_BANKS*BANK_SZ records, newest at index 0, read through
// a bank code and an in-bank index. Assumes BANK_SZ is a power of two and
// NUM_BANKS is at most 4 (bank code is 2 bits).
module brb_store #(
    parameter int AW        = 32,
    parameter int BANK_SZ   = 32,
    parameter int NUM_BANKS = 2,
    localparam int DEPTH    = BANK_SZ * NUM_BANKS,
    localparam int IDXW     = $clog2(BANK_SZ),
    localparam int DW       = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [AW-1:0]   in_src,
    input  logic [AW-1:0]   in_tgt,
    input  logic [2:0]      in_cls,
    input  logic            in_fail,
    input  logic [1:0]      bank,
    input  logic [IDXW-1:0] idx,
    output logic            out_valid,
    output logic [AW-1:0]   out_src,
    output logic [AW-1:0]   out_tgt,
    output logic [2:0]      out_cls,
    output logic            out_fail
);

    typedef struct packed {
        logic          valid;
        logic [AW-1:0] src;
        logic [AW-1:0] tgt;
        logic [2:0]    cls;
        logic          fail;
    } rec_t;

    rec_t ent [DEPTH];
    rec_t incoming;
    rec_t sel;
    logic [IDXW+1:0] flat;

    // Record built from the current branch
    always_comb incoming = '{valid: 1'b1, src: in_src, tgt: in_tgt,
                             cls: in_cls, fail: in_fail};

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Each slot takes the newer neighbour's record on a push
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent[g] <= '0;
            else if (push)
                ent[g] <= (g == 0) ? incoming : ent[(g == 0) ? 0 : g-1];
        end
    end

    // Flatten bank and index, return zeros outside the implemented banks
    always_comb begin
        flat = {bank, idx};
        if (int'(bank) < NUM_BANKS)
            sel = ent[flat[DW-1:0]];
        else
            sel = '0;
    end

    assign out_valid = sel.valid;
    assign out_src   = sel.src;
    assign out_tgt   = sel.tgt;
    assign out_cls   = sel.cls;
    assign out_fail  = sel.fail;

    // R6
    head_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> ent[0].valid);

    // R5
    hold_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(ent[0]));

    // R5
    hold_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !push |=> $stable(ent[DEPTH-1]));

endmodule

// File: rtl/brb_capture.sv
// Module: brb_capture (top)
// Filters retired branches under the control word and pushes the kept ones
// into the record store. Assumes one branch per cycle at most and that the
// failure pulse is a single-cycle event.
module brb_capture
    import brb_pkg::*;
#(
    parameter int AW        = 32,
    parameter int BANK_SZ   = 32,
    parameter int NUM_BANKS = 2,
    localparam int IDXW     = $clog2(BANK_SZ)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            br_valid,
    input  logic [2:0]      br_class,
    input  logic [AW-1:0]   br_src,
    input  logic [AW-1:0]   br_tgt,
    input  logic            br_fail,
    input  logic [IDXW-1:0] rd_idx,
    output logic            rd_valid,
    output logic [AW-1:0]   rd_src,
    output logic [AW-1:0]   rd_tgt,
    output logic [2:0]      rd_class,
    output logic            rd_fail
);

    logic [1:0]      ctl_bank;
    logic [N_EN-1:0] ctl_en;
    logic            ctl_inv;
    logic            ctl_pause;
    logic            ctl_fail;
    logic            keep;
    logic            rec_push;
    logic            rec_fail;

    brb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .fail_in   (br_fail),
        .push      (rec_push),
        .rdata     (reg_rdata),
        .bank      (ctl_bank),
        .en        (ctl_en),
        .inv       (ctl_inv),
        .pause     (ctl_pause),
        .fail_flag (ctl_fail)
    );

    brb_filter u_filter (
        .cls  (br_class),
        .en   (ctl_en),
        .inv  (ctl_inv),
        .keep (keep)
    );

    // Push when a kept branch arrives and capture is not paused
    always_comb rec_push = br_valid && keep && !ctl_pause;

    // A same-cycle failure rides on the new record
    always_comb rec_fail = ctl_fail | br_fail;

    brb_store #(
        .AW        (AW),
        .BANK_SZ   (BANK_SZ),
        .NUM_BANKS (NUM_BANKS)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rec_push),
        .in_src    (br_src),
        .in_tgt    (br_tgt),
        .in_cls    (br_class),
        .in_fail   (rec_fail),
        .bank      (ctl_bank),
        .idx       (rd_idx),
        .out_valid (rd_valid),
        .out_src   (rd_src),
        .out_tgt   (rd_tgt),
        .out_cls   (rd_class),
        .out_fail  (rd_fail)
    );

    // R7
    rsvd_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ctl_bank) >= NUM_BANKS) |-> !rd_valid);

    // R5
    pause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_pause && !br_fail && !reg_wr) |=> $stable(ctl_fail));

endmodule

// File: tb/tb_brb_capture.sv
module tb_brb_capture;

    localparam int CLK_PERIOD = 10;
    localparam int AW   = 32;
    localparam int NREC = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          br_valid = 1'b0;
    logic [2:0]    br_class = '0;
    logic [AW-1:0] br_src = '0;
    logic [AW-1:0] br_tgt = '0;
    logic          br_fail = 1'b0;
    logic [4:0]    rd_idx = '0;
    logic          rd_valid;
    logic [AW-1:0] rd_src;
    logic [AW-1:0] rd_tgt;
    logic [2:0]    rd_class;
    logic          rd_fail;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0]   m_ctl;
    logic          m_flag;
    logic          m_v   [NREC];
    logic [AW-1:0] m_s   [NREC];
    logic [AW-1:0] m_t   [NREC];
    logic [2:0]    m_c   [NREC];
    logic          m_f   [NREC];

    brb_capture dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bit position of a class enable, -1 for codes that match nothing
    function automatic int en_bit(input logic [2:0] c);
        case (c)
            3'd0: return 17;
            3'd1: return 18;
            3'd4: return 19;
            3'd3: return 20;
            3'd2: return 21;
            default: return -1;
        endcase
    endfunction

    function automatic bit kept(input logic [31:0] ctl, input logic [2:0] c);
        bit hit;
        int p;
        p = en_bit(c);
        hit = (p >= 0) ? ctl[p] : 1'b0;
        return hit ^ ctl[16];
    endfunction

    function automatic logic [31:0] exp_rdata();
        logic [31:0] r;
        r = m_ctl & 32'h303F_0080;
        r[6] = m_flag;
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_ctl = '0;
        m_flag = 1'b0;
        for (int i = 0; i < NREC; i++) begin
            m_v[i] = 0; m_s[i] = '0; m_t[i] = '0; m_c[i] = '0; m_f[i] = 0;
        end
    endtask

    // One clock: drive at negedge, update the model, release just after the edge
    task automatic step(input bit wr, input logic [31:0] wd, input bit bv,
                        input logic [2:0] c, input logic [AW-1:0] s,
                        input logic [AW-1:0] t, input bit fl);
        bit push;
        @(negedge clk);
        reg_wr = wr; reg_wdata = wd; br_valid = bv; br_class = c;
        br_src = s; br_tgt = t; br_fail = fl;
        push = bv && kept(m_ctl, c) && !m_ctl[7];
        @(posedge clk);
        if (push) begin
            for (int i = NREC-1; i > 0; i--) begin
                m_v[i] = m_v[i-1]; m_s[i] = m_s[i-1]; m_t[i] = m_t[i-1];
                m_c[i] = m_c[i-1]; m_f[i] = m_f[i-1];
            end
            m_v[0] = 1; m_s[0] = s; m_t[0] = t; m_c[0] = c; m_f[0] = m_flag | fl;
            m_flag = 1'b0;
        end else begin
            m_flag = (wr ? wd[6] : m_flag) | fl;
        end
        if (wr) m_ctl = wd & 32'h303F_0080;
        #1;
        reg_wr = 0; br_valid = 0; br_fail = 0;
    endtask

    task automatic check_ctl(input string req);
        #1;
        check(req, {96'd0, reg_rdata}, {96'd0, exp_rdata()});
    endtask

    // Read one record through the current bank and compare with the model
    task automatic check_rec(input string req, input logic [4:0] i);
        logic [69:0] exp;
        int b;
        int k;
        rd_idx = i;
        #1;
        b = int'(m_ctl[29:28]);
        k = b * 32 + int'(i);
        if (b < 2) exp = {m_v[k], m_s[k], m_t[k], m_c[k], m_f[k]};
        else       exp = '0;
        check(req, {58'd0, rd_valid, rd_src, rd_tgt, rd_class, rd_fail},
              {58'd0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        check_ctl("R1");
        check_rec("R1", 5'd0);
        step(1, 32'h1000_0000, 0, 0, 0, 0, 0);
        check_rec("R1", 5'd31);

        // R2: reserved bits ignored, fields read back
        step(1, 32'hFFFF_FF3F, 0, 0, 0, 0, 0);
        check_ctl("R2");
        // R2: write cycle filters with old word (old word excludes all but reserved codes)
        step(1, 32'h0002_0000, 1, 3'd0, 32'h11, 32'h22, 0);
        check_rec("R2", 5'd0);
        check_ctl("R2");

        // R3: direct enabled, indirect not
        step(0, 0, 1, 3'd0, 32'hA0, 32'hB0, 0);
        step(0, 0, 1, 3'd1, 32'hA1, 32'hB1, 0);
        check_rec("R3", 5'd0);
        check_rec("R3", 5'd1);

        // R4: invert, class 7 kept, direct dropped
        step(1, 32'h0003_0000, 0, 0, 0, 0, 0);
        step(0, 0, 1, 3'd7, 32'hC7, 32'hD7, 0);
        step(0, 0, 1, 3'd0, 32'hC0, 32'hD0, 0);
        check_rec("R4", 5'd0);

        // R9: same-cycle failure on kept branch, then on dropped branch
        step(0, 0, 1, 3'd4, 32'hE4, 32'hF4, 1);
        check_rec("R9", 5'd0);
        check_ctl("R9");
        step(0, 0, 1, 3'd0, 32'hE0, 32'hF0, 1);
        check_ctl("R8");
        step(0, 0, 1, 3'd2, 32'hE2, 32'hF2, 0);
        check_rec("R9", 5'd0);
        check_ctl("R9");

        // R5: pause blocks capture and keeps records
        step(1, 32'h0001_0080, 0, 0, 0, 0, 0);
        step(0, 0, 1, 3'd1, 32'h55, 32'h66, 0);
        check_rec("R5", 5'd0);
        check_rec("R5", 5'd1);

        // R6: overflow, oldest dropped
        step(1, 32'h0010_0000, 0, 0, 0, 0, 0);
        for (int n = 0; n < 70; n++) step(0, 0, 1, 3'd3, 32'h1000 + n, 32'h2000 + n, 0);
        check_rec("R6", 5'd0);
        step(1, 32'h1010_0000, 0, 0, 0, 0, 0);
        check_rec("R6", 5'd31);

        // R7: reserved bank stored and reads zero
        step(1, 32'h2010_0000, 0, 0, 0, 0, 0);
        check_ctl("R7");
        check_rec("R7", 5'd3);

        // R8/R10: random mix
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] wd;
            bit wr;
            wr = ($urandom % 8) == 0;
            wd = $urandom;
            if (($urandom % 6) != 0) wd[29] = 1'b0;
            if (($urandom % 4) != 0) wd[7] = 1'b0;
            step(wr, wd, ($urandom % 10) < 7, 3'($urandom), $urandom, $urandom,
                 ($urandom % 6) == 0);
            check_ctl("R8");
            check_rec("R10", 5'($urandom));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule